// File: doc/BRIEF.md
# I2C Output Expander with Bus-Hold Latching

This block is an I2C target that owns one 8-bit output register and drives a general-purpose output port from it. A controller writes the register with a write transfer (address byte with bit 0 clear, then any number of data bytes) and reads it back with a read transfer (address byte with bit 0 set). Each data byte of a write enters the register at the falling SCL edge that ends its acknowledge bit. The 7-bit target address is a parameter. SCL and SDA are sampled with the system clock through a two-stage synchroniser. The target pulls SDA low through `sda_drive_low`, which the pad turns into an open-drain pull-down.

A static configuration input, `latch_en`, selects the latching behaviour. When it is high, the whole output port holds its levels from the START condition onward, whatever the register does in the meantime. In a write transfer the hold lasts until STOP. In a read transfer it ends when the address byte's acknowledge bit ends. In both cases the hold also ends at once when the address does not match. When the hold ends, the port loads the latest register value in one clock, so all pins change together. When `latch_en` is low the port follows the register one clock after each update.

The transfer state machine has these states: IDLE, ADDR (shifting the address byte), ADDR_ACK (target acknowledges), WDATA (shifting a write byte), WACK (acknowledging it and committing it on the closing SCL fall), RDATA (driving a read byte MSB first), RACK (sampling the controller's acknowledge) and IGNORE (waiting after a mismatch or a controller NACK). STOP leads from any state to IDLE, and START from any state to ADDR. ADDR leads to ADDR_ACK on a match and to IGNORE on a mismatch, after the eighth bit. ADDR_ACK leads to RDATA or WDATA according to the direction bit. WDATA and WACK alternate. RDATA leads to RACK after eight bits, and RACK leads back to RDATA on an acknowledge or to IGNORE on a NACK.

Top module: `i2c_hold_expander`

## Requirements
- R1: After a synchronous active-high reset, the output port and the register are zero, SDA is released and the state machine is idle.
- R2: The target acknowledges (SDA low during the ninth clock) an address byte whose bits 7..1 equal TARGET_ADDR. Bit 0 of that byte selects read (1) or write (0).
- R3: After an address byte that does not match, the target gives no acknowledge, ignores the bus until the next START or STOP, and releases any hold at once.
- R4: Each data byte of a write is acknowledged and enters the register at the SCL falling edge that ends its acknowledge bit. Before that edge the register keeps its old value.
- R5: While no hold is active, the output port equals the register value of the previous clock.
- R6: With `latch_en` high, a write transfer holds every output pin from START until STOP. After STOP the port shows the last byte written.
- R7: With `latch_en` high, a read transfer releases the hold at the end of the address acknowledge bit.
- R8: A repeated START keeps an active hold and re-evaluates the direction from the new address byte.
- R9: A read returns the register MSB first. It continues with another copy of the register after a controller ACK and stops driving SDA after a NACK.
- R10: The register is updated at every write acknowledge whether or not `latch_en` is high. With `latch_en` low, no hold ever occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| latch_en | input | 1 | Static option: hold the outputs during transfers |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_drive_low | output | 1 | 1 pulls SDA low (open-drain) |
| gpo | output | 8 | General-purpose output port |

## Verification
The bench builds the block with TARGET_ADDR = 0x2A and two synchroniser stages, with a bus bit of 24 system clocks. With these values, all 128 address values are swept through one address phase each, with the acknowledge expected only at 0x2A. All 256 data values are written in one long unlatched write, and the port is checked both just before and just after each acknowledge. Latched write, read, repeated-START and mismatch sequences then show the hold windows and the one-clock release at the port.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } xfer_state_t;
endpackage

// File: rtl/i2cx_line_sync.sv
module i2cx_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic scl_p;
    logic sda_p;

    // Multi-stage synchronisers, idle level is high.
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_in};
            scl_p    <= scl_pipe[SYNC_STAGES-1];
            sda_p    <= sda_pipe[SYNC_STAGES-1];
        end
    end

    always_comb begin
        scl_s    = scl_pipe[SYNC_STAGES-1];
        sda_s    = sda_pipe[SYNC_STAGES-1];
        scl_rise = scl_s && !scl_p;
        scl_fall = !scl_s && scl_p;
        start_ev = scl_s && scl_p && sda_p && !sda_s;
        stop_ev  = scl_s && scl_p && !sda_p && sda_s;
    end
endmodule

// File: rtl/i2cx_target_fsm.sv
module i2cx_target_fsm
    import i2cx_pkg::*;
#(
    parameter logic [ADDR_W-1:0] TARGET_ADDR = 7'h2A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    output logic              sda_drive_low,
    output logic              hold_rel,
    output logic [BYTE_W-1:0] wreg_q,
    output xfer_state_t       state_q
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    xfer_state_t       state_d;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] tx_q;
    logic              mack_q;
    logic              addr_hit;
    logic              byte_end;

    always_comb begin
        addr_hit = (shreg[BYTE_W-1:1] == TARGET_ADDR);
        byte_end = scl_fall && (bit_cnt == FULL_CNT);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_ev) begin
            state_d = ST_IDLE;
        end else if (start_ev) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (byte_end) state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) state_d = shreg[0] ? ST_RDATA : ST_WDATA;
                ST_WDATA:    if (byte_end) state_d = ST_WACK;
                ST_WACK:     if (scl_fall) state_d = ST_WDATA;
                ST_RDATA:    if (scl_fall && bit_cnt == LAST_BIT) state_d = ST_RACK;
                ST_RACK:     if (scl_fall) state_d = mack_q ? ST_RDATA : ST_IGNORE;
                ST_IGNORE:   state_d = ST_IGNORE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Datapath: shifter, bit counter, register, read shifter
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
            shreg   <= '0;
            tx_q    <= '0;
            wreg_q  <= '0;
            mack_q  <= 1'b0;
        end else if (start_ev || stop_ev) begin
            bit_cnt <= '0;
        end else begin
            case (state_q)
                ST_ADDR, ST_WDATA: begin
                    if (scl_rise && bit_cnt != FULL_CNT) begin
                        shreg   <= {shreg[BYTE_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        tx_q    <= wreg_q;
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        wreg_q  <= shreg;
                        bit_cnt <= '0;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (bit_cnt == LAST_BIT) begin
                            bit_cnt <= '0;
                        end else begin
                            tx_q    <= {tx_q[BYTE_W-2:0], 1'b0};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) mack_q <= !sda_s;
                    if (scl_fall) begin
                        tx_q    <= wreg_q;
                        bit_cnt <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        sda_drive_low = (state_q == ST_ADDR_ACK) || (state_q == ST_WACK) ||
                        ((state_q == ST_RDATA) && !tx_q[BYTE_W-1]);
        hold_rel = !start_ev && !stop_ev &&
                   (((state_q == ST_ADDR) && byte_end && !addr_hit) ||
                    ((state_q == ST_ADDR_ACK) && scl_fall && shreg[0]));
    end
endmodule

// File: rtl/i2cx_hold_gate.sv
module i2cx_hold_gate
    import i2cx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              latch_en,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              hold_rel,
    input  logic [BYTE_W-1:0] wreg_q,
    output logic              hold_q,
    output logic [BYTE_W-1:0] gpo
);
    always_ff @(posedge clk) begin
        if (rst)                      hold_q <= 1'b0;
        else if (!latch_en)           hold_q <= 1'b0;
        else if (start_ev)            hold_q <= 1'b1;
        else if (stop_ev || hold_rel) hold_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)          gpo <= '0;
        else if (!hold_q) gpo <= wreg_q;
    end
endmodule

// File: rtl/i2c_hold_expander.sv
module i2c_hold_expander
    import i2cx_pkg::*;
#(
    parameter logic [ADDR_W-1:0] TARGET_ADDR = 7'h2A,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              latch_en,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_drive_low,
    output logic [BYTE_W-1:0] gpo
);
    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_ev;
    logic              stop_ev;
    logic              hold_rel;
    logic              hold_q;
    logic [BYTE_W-1:0] wreg_q;
    xfer_state_t       fsm_state;

    i2cx_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    i2cx_target_fsm #(.TARGET_ADDR(TARGET_ADDR)) u_fsm (
        .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
        .sda_drive_low(sda_drive_low), .hold_rel(hold_rel),
        .wreg_q(wreg_q), .state_q(fsm_state)
    );

    i2cx_hold_gate u_gate (
        .clk(clk), .rst(rst), .latch_en(latch_en), .start_ev(start_ev),
        .stop_ev(stop_ev), .hold_rel(hold_rel), .wreg_q(wreg_q),
        .hold_q(hold_q), .gpo(gpo)
    );

    logic unused_scl;
    assign unused_scl = scl_s;
endmodule

// File: rtl/i2c_hold_expander_chk.sv
module i2c_hold_expander_chk
    import i2cx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              latch_en,
    input logic              sda_drive_low,
    input logic [BYTE_W-1:0] gpo,
    input logic              hold_q,
    input logic [BYTE_W-1:0] wreg_q,
    input xfer_state_t       fsm_state
);
    // R5
    gpo_follows_chk: assert property (@(posedge clk) disable iff (rst)
        !hold_q |=> gpo == $past(wreg_q));

    // R6
    gpo_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        hold_q |=> $stable(gpo));

    // R10
    no_hold_unlatched_chk: assert property (@(posedge clk) disable iff (rst)
        !latch_en |=> !hold_q);

    // R7
    read_released_chk: assert property (@(posedge clk) disable iff (rst)
        fsm_state == ST_RDATA |-> !hold_q);

    // R3
    ignore_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        fsm_state == ST_IGNORE |-> !sda_drive_low);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        fsm_state == ST_IDLE |-> !sda_drive_low);
endmodule

bind i2c_hold_expander i2c_hold_expander_chk u_chk (
    .clk(clk), .rst(rst), .latch_en(latch_en), .sda_drive_low(sda_drive_low),
    .gpo(gpo), .hold_q(hold_q), .wreg_q(wreg_q), .fsm_state(fsm_state)
);

// File: tb/i2c_hold_expander_tb.sv
module i2c_hold_expander_tb;
    localparam logic [6:0] TADDR = 7'h2A;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic latch_en = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_drive_low;
    logic [7:0] gpo;
    logic sda_line;
    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;
    assign sda_line = sda_m & ~sda_drive_low;

    i2c_hold_expander #(.TARGET_ADDR(TADDR)) u_dut (
        .clk(clk), .rst(rst), .latch_en(latch_en), .scl_in(scl_m),
        .sda_in(sda_line), .sda_drive_low(sda_drive_low), .gpo(gpo)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(Q);
        scl_m = 1'b1; wt(Q);
        sda_m = 1'b0; wt(Q);
        scl_m = 1'b0; wt(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(Q);
        scl_m = 1'b1; wt(Q);
        sda_m = 1'b1; wt(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    wt(Q);
        scl_m = 1'b1; wt(2*Q);
        scl_m = 1'b0; wt(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wt(Q);
        scl_m = 1'b1; wt(Q);
        b = sda_line; wt(Q);
        scl_m = 1'b0; wt(Q);
    endtask

    task automatic put_bits(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
    endtask

    task automatic put_byte(input logic [7:0] v, output logic acked);
        logic b;
        put_bits(v);
        get_bit(b);
        acked = !b;
    endtask

    task automatic get_byte(output logic [7:0] v, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!give_ack);
    endtask

    task automatic read_reg(output logic [7:0] v);
        logic a;
        bus_start();
        put_byte({TADDR, 1'b1}, a);
        get_byte(v, 1'b0);
        bus_stop();
    endtask

    initial begin
        wt(200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] v;
        logic [7:0] prev;
        wt(5);
        rst = 1'b0;
        wt(2);
        // R1: reset state
        chk("R1 gpo", gpo, 8'h00);
        chk("R1 sda", sda_drive_low, 1'b0);
        read_reg(v);
        chk("R1 reg", v, 8'h00);

        // R2 R3: address sweep, acknowledge only at the target address
        for (int ad = 0; ad < 128; ad++) begin
            bus_start();
            put_byte({ad[6:0], 1'b0}, a);
            chk(ad == TADDR ? "R2 ack" : "R3 nack", a, (ad == TADDR));
            bus_stop();
        end

        // R4 R5: unlatched write of every byte value
        prev = 8'h00;
        bus_start();
        put_byte({TADDR, 1'b0}, a);
        for (int d = 0; d < 256; d++) begin
            put_bits(d[7:0]);
            chk("R4 before ack", gpo, prev);
            get_bit(a);
            chk("R4 ack", a, 1'b0);
            wt(3);
            chk("R5 follow", gpo, d[7:0]);
            prev = d[7:0];
        end
        bus_stop();

        // R6 R10: latched write holds until STOP
        latch_en = 1'b1;
        wt(4);
        bus_start();
        put_byte({TADDR, 1'b0}, a);
        chk("R6 held addr", gpo, 8'hFF);
        put_byte(8'h5A, a);
        chk("R6 held d0", gpo, 8'hFF);
        put_byte(8'h3C, a);
        chk("R6 held d1", gpo, 8'hFF);
        bus_stop();
        wt(4);
        chk("R6 release", gpo, 8'h3C);

        // R7 R8 R10: register changes under hold, repeated START to read
        bus_start();
        put_byte({TADDR, 1'b0}, a);
        put_byte(8'h81, a);
        chk("R10 held", gpo, 8'h3C);
        bus_start();
        put_bits({TADDR, 1'b1});
        chk("R8 hold kept", gpo, 8'h3C);
        get_bit(a);
        wt(3);
        chk("R7 read release", gpo, 8'h81);
        get_byte(v, 1'b0);
        chk("R9 read data", v, 8'h81);
        chk("R9 sda free", sda_drive_low, 1'b0);
        bus_stop();

        // R8: repeated START inside a write keeps the hold
        bus_start();
        put_byte({TADDR, 1'b0}, a);
        put_byte(8'h11, a);
        bus_start();
        put_byte({TADDR, 1'b0}, a);
        chk("R8 rs write held", gpo, 8'h81);
        put_byte(8'h22, a);
        chk("R8 still held", gpo, 8'h81);
        bus_stop();
        wt(4);
        chk("R8 final", gpo, 8'h22);

        // R3: mismatch after repeated START releases the hold at once
        bus_start();
        put_byte({TADDR, 1'b0}, a);
        put_byte(8'h77, a);
        chk("R3 held", gpo, 8'h22);
        bus_start();
        put_bits({7'h15, 1'b0});
        wt(3);
        chk("R3 release", gpo, 8'h77);
        get_bit(a);
        chk("R3 nack", a, 1'b1);
        put_byte(8'h00, a);
        chk("R3 data nack", a, 1'b0);
        bus_stop();
        latch_en = 1'b0;
        read_reg(v);
        chk("R3 ignored data", v, 8'h77);

        // R9: multi-byte read with controller ACK then NACK
        bus_start();
        put_byte({TADDR, 1'b0}, a);
        put_byte(8'hA5, a);
        bus_stop();
        bus_start();
        put_byte({TADDR, 1'b1}, a);
        chk("R2 read ack", a, 1'b1);
        get_byte(v, 1'b1);
        chk("R9 first", v, 8'hA5);
        get_byte(v, 1'b0);
        chk("R9 second", v, 8'hA5);
        chk("R9 released", sda_drive_low, 1'b0);
        bus_stop();
        chk("R10 unlatched gpo", gpo, 8'hA5);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule